// File: doc/BRIEF.md
# DMA Page Translation Unit

This block maps logical DMA addresses onto physical addresses in pages of 4096 bytes. The mapping comes from a page table in system memory. Each table entry is 8 bytes long: a 32-bit frame word at byte offset 0, then a 32-bit owner word at byte offset 4. A frame word of zero means the page is unmapped. Software sets the table's physical location with a base register and its size in bytes with a limit register. A write to either register discards the cached copy of the table and fetches it again over a single-outstanding memory-read port. Only the frame word of each entry is read.

A DMA engine presents a logical address on the lookup port. One cycle after the lookup is accepted, the block answers with either a physical address or a fault. While a table reload is running, lookups are held off by a ready signal. The block also watches 32-bit writes to memory. A write that lands on a frame word inside the table region updates the cached entry at once, so a later lookup does not need a new reload to see it.

Top module: `dma_xlate_unit`

## Requirements
- R1: After reset, the base and limit registers both read 0, and every lookup returns a fault.
- R2: A lookup on a mapped page returns a response one cycle after it is accepted. The physical address is the frame word with its low 12 bits replaced by bits 11:0 of the logical address, and the fault flag is 0.
- R3: A lookup that hits an entry whose frame word is zero returns a fault.
- R4: The number of usable entries is min(limit/8, 512). A lookup whose page index (logical address bits 31:12) is at or above that count, or at or above 512, returns a fault.
- R5: Table fetch reads go to (base AND 0x7FFFFFFF) + 8*i. Bit 31 of the base is ignored for fetching but is kept in the register and reads back.
- R6: Writing the base register or the limit register invalidates every cached entry and refetches the table from the current base. A reload that starts while another is running supersedes it, and a read response from the superseded reload is discarded.
- R7: A limit of 0 issues no fetch reads, and every page reads as unmapped.
- R8: A snooped write whose address is 8-byte aligned and inside the region [base, base + 8*usable entries) replaces that entry's frame, and the change is visible to the very next lookup. Snooped writes to an owner word (offset 4) or outside the region change no translation.
- R9: lk_ready_o goes low in the cycle after a register write and stays low until the last entry is fetched. A lookup held during this time produces no response until it is accepted.
- R10: A reload issues exactly min(limit/8, 512) fetch reads, one at a time. mem_req_o is never high in two consecutive cycles.
- R11: reg_rdata_o shows the base register when reg_sel_i is 0 and the limit register when reg_sel_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 base, 1 limit |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Selected register value |
| mem_req_o | output | 1 | Table fetch read request, one cycle |
| mem_addr_o | output | 32 | Table fetch physical address |
| mem_rvalid_i | input | 1 | Fetch read data valid |
| mem_rdata_i | input | 32 | Fetch read data (frame word) |
| snp_valid_i | input | 1 | Snooped 32-bit memory write valid |
| snp_addr_i | input | 32 | Snooped write physical address |
| snp_data_i | input | 32 | Snooped write data |
| lk_valid_i | input | 1 | Lookup request valid |
| lk_addr_i | input | 32 | Logical address to translate |
| lk_ready_o | output | 1 | Lookup can be accepted (no reload running) |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_fault_o | output | 1 | Page unmapped or out of range |
| rsp_paddr_o | output | 32 | Translated physical address (0 on fault) |

## Verification
A lookup response is registered and appears one cycle after the clock edge that accepts the lookup. The bench raises lk_valid_i on a falling edge, holds it until lk_ready_o is high, and samples the response on the next falling edge. A register write lands on one edge, and lk_ready_o is low at the falling edge right after it, so the stall is checked there. Reload completion is never timed against a fixed cycle count. The bench waits for lk_ready_o and then compares the number of fetch reads and the first fetch address taken from a memory model with a two-cycle latency. A snoop is applied on one edge and the lookup that follows immediately must already show the new frame.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
  localparam int unsigned AW     = 32;
  localparam int unsigned PG_W   = 12;
  localparam int unsigned PFN_W  = AW - PG_W;
  localparam int unsigned ENT_SH = 3;

  typedef struct packed {
    logic             valid;
    logic [PFN_W-1:0] pfn;
  } dxl_entry_t;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ISSUE = 2'd1,
    FS_WAIT  = 2'd2
  } dxl_fstate_e;
endpackage

// File: rtl/dxl_regs.sv
module dxl_regs
  import dxl_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 512,
  parameter int unsigned CNT_W       = $clog2(MAX_ENTRIES) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [AW-1:0]    wdata_i,
  output logic [AW-1:0]    rdata_o,
  output logic [AW-1:0]    base_o,
  output logic [CNT_W-1:0] n_used_o,
  output logic             reload_o
);
  localparam int unsigned LE_W = AW - ENT_SH;
  localparam logic [LE_W-1:0] MAX_LE = LE_W'(MAX_ENTRIES);

  logic [AW-1:0]   base_q, limit_q;
  logic            reload_q;
  logic [LE_W-1:0] lim_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      limit_q  <= '0;
      reload_q <= 1'b0;
    end else begin
      reload_q <= we_i;
      if (we_i && !sel_i) base_q  <= wdata_i;
      if (we_i &&  sel_i) limit_q <= wdata_i;
    end
  end

  assign lim_ent  = limit_q[AW-1:ENT_SH];
  assign n_used_o = (lim_ent >= MAX_LE) ? CNT_W'(MAX_ENTRIES) : CNT_W'(lim_ent);
  assign base_o   = {1'b0, base_q[AW-2:0]};
  assign rdata_o  = sel_i ? limit_q : base_q;
  assign reload_o = reload_q;

  // R11
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !sel_i) |=> (base_o[AW-2:0] == $past(wdata_i[AW-2:0])));
endmodule

// File: rtl/dxl_fetch.sv
module dxl_fetch
  import dxl_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 512,
  parameter int unsigned IDX_W       = $clog2(MAX_ENTRIES),
  parameter int unsigned CNT_W       = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] n_used_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             fill_we_o,
  output logic [IDX_W-1:0] fill_idx_o,
  output logic [AW-1:0]    fill_data_o,
  output logic             busy_o
);
  dxl_fstate_e      state_q, state_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             pend_q, drop_q;
  logic             last;
  logic [AW-1:0]    sum;

  assign last       = (idx_q == n_used_i - CNT_W'(1));
  assign mem_req_o  = (state_q == FS_ISSUE) && !pend_q && !reload_i;
  assign sum        = base_i + {{(AW-CNT_W-ENT_SH){1'b0}}, idx_q, {ENT_SH{1'b0}}};
  assign mem_addr_o = {1'b0, sum[AW-2:0]};
  assign fill_we_o  = mem_rvalid_i && pend_q && !drop_q && (state_q == FS_WAIT) && !reload_i;
  assign fill_idx_o = idx_q[IDX_W-1:0];
  assign fill_data_o = mem_rdata_i;
  assign busy_o     = reload_i || (state_q != FS_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (reload_i) begin
      idx_d   = '0;
      state_d = (n_used_i == '0) ? FS_IDLE : FS_ISSUE;
    end else begin
      unique case (state_q)
        FS_ISSUE: if (mem_req_o) state_d = FS_WAIT;
        FS_WAIT: if (fill_we_o) begin
          if (last) state_d = FS_IDLE;
          else begin
            idx_d   = idx_q + CNT_W'(1);
            state_d = FS_ISSUE;
          end
        end
        default: state_d = FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      drop_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      if (mem_req_o)         pend_q <= 1'b1;
      else if (mem_rvalid_i) pend_q <= 1'b0;
      // a read in flight when a new reload starts belongs to the old table
      if (reload_i && pend_q && !mem_rvalid_i) drop_q <= 1'b1;
      else if (mem_rvalid_i)                   drop_q <= 1'b0;
    end
  end

  // R10
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  // R5
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (!mem_addr_o[AW-1] && mem_addr_o[ENT_SH-1:0] == '0));
  // R10
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != FS_IDLE) |-> (idx_q < n_used_i));
endmodule

// File: rtl/dxl_table.sv
module dxl_table
  import dxl_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 512,
  parameter int unsigned IDX_W       = $clog2(MAX_ENTRIES),
  parameter int unsigned CNT_W       = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] n_used_i,
  input  logic             fill_we_i,
  input  logic [IDX_W-1:0] fill_idx_i,
  input  logic [AW-1:0]    fill_data_i,
  input  logic             snp_valid_i,
  input  logic [AW-1:0]    snp_addr_i,
  input  logic [AW-1:0]    snp_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output dxl_entry_t       rd_entry_o
);
  localparam int unsigned OE_W = AW - ENT_SH;

  dxl_entry_t       ent_q [MAX_ENTRIES];
  logic [AW-1:0]    off;
  logic             snp_hit;
  logic [IDX_W-1:0] snp_idx;

  assign off     = snp_addr_i - base_i;
  assign snp_hit = snp_valid_i && (off[ENT_SH-1:0] == '0) &&
                   (off[AW-1:ENT_SH] < {{(OE_W-CNT_W){1'b0}}, n_used_i});
  assign snp_idx = off[IDX_W+ENT_SH-1:ENT_SH];

  for (genvar g = 0; g < MAX_ENTRIES; g++) begin : g_ent
    logic snp_we, fil_we;
    assign snp_we = snp_hit   && (snp_idx    == IDX_W'(g));
    assign fil_we = fill_we_i && (fill_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ent_q[g] <= '0;
      else if (clear_i) ent_q[g].valid <= 1'b0;
      else if (snp_we)  ent_q[g] <= '{valid: (snp_data_i != '0), pfn: snp_data_i[AW-1:PG_W]};
      else if (fil_we)  ent_q[g] <= '{valid: (fill_data_i != '0), pfn: fill_data_i[AW-1:PG_W]};
    end
  end

  assign rd_entry_o = ent_q[rd_idx_i];

  // R6
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !ent_q[0].valid);
endmodule

// File: rtl/dxl_lookup.sv
module dxl_lookup
  import dxl_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 512,
  parameter int unsigned IDX_W       = $clog2(MAX_ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lk_valid_i,
  input  logic [AW-1:0]    lk_addr_i,
  input  logic             lk_ready_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  dxl_entry_t       rd_entry_i,
  output logic             rsp_valid_o,
  output logic             rsp_fault_o,
  output logic [AW-1:0]    rsp_paddr_o
);
  logic [PFN_W-1:0] page;
  logic             in_rng, fault, acc;

  assign page     = lk_addr_i[AW-1:PG_W];
  assign in_rng   = page < PFN_W'(MAX_ENTRIES);
  assign rd_idx_o = page[IDX_W-1:0];
  assign fault    = !in_rng || !rd_entry_i.valid;
  assign acc      = lk_valid_i && lk_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= acc;
      if (acc) begin
        rsp_fault_o <= fault;
        rsp_paddr_o <= fault ? '0 : {rd_entry_i.pfn, lk_addr_i[PG_W-1:0]};
      end
    end
  end

  // R9
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_ready_i |=> !rsp_valid_o);
  // R2
  offset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !fault) |=> (rsp_paddr_o[PG_W-1:0] == $past(lk_addr_i[PG_W-1:0])));
endmodule

// File: rtl/dma_xlate_unit.sv
module dma_xlate_unit
  import dxl_pkg::*;
#(
  parameter int unsigned MAX_ENTRIES = 512
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic        reg_sel_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  input  logic        snp_valid_i,
  input  logic [31:0] snp_addr_i,
  input  logic [31:0] snp_data_i,
  input  logic        lk_valid_i,
  input  logic [31:0] lk_addr_i,
  output logic        lk_ready_o,
  output logic        rsp_valid_o,
  output logic        rsp_fault_o,
  output logic [31:0] rsp_paddr_o
);
  localparam int unsigned IDX_W = $clog2(MAX_ENTRIES);
  localparam int unsigned CNT_W = IDX_W + 1;

  logic [AW-1:0]    base_m;
  logic [CNT_W-1:0] n_used;
  logic             reload, busy;
  logic             fill_we;
  logic [IDX_W-1:0] fill_idx, rd_idx;
  logic [AW-1:0]    fill_data;
  dxl_entry_t       rd_entry;

  dxl_regs #(.MAX_ENTRIES(MAX_ENTRIES), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .base_o(base_m), .n_used_o(n_used), .reload_o(reload)
  );

  dxl_fetch #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_fetch (
    .clk_i, .rst_ni,
    .reload_i(reload), .base_i(base_m), .n_used_i(n_used),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .fill_we_o(fill_we), .fill_idx_o(fill_idx), .fill_data_o(fill_data),
    .busy_o(busy)
  );

  dxl_table #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk_i, .rst_ni,
    .clear_i(reload), .base_i(base_m), .n_used_i(n_used),
    .fill_we_i(fill_we), .fill_idx_i(fill_idx), .fill_data_i(fill_data),
    .snp_valid_i, .snp_addr_i, .snp_data_i,
    .rd_idx_i(rd_idx), .rd_entry_o(rd_entry)
  );

  assign lk_ready_o = !busy;

  dxl_lookup #(.MAX_ENTRIES(MAX_ENTRIES), .IDX_W(IDX_W)) u_lookup (
    .clk_i, .rst_ni,
    .lk_valid_i, .lk_addr_i, .lk_ready_i(lk_ready_o),
    .rd_idx_o(rd_idx), .rd_entry_i(rd_entry),
    .rsp_valid_o, .rsp_fault_o, .rsp_paddr_o
  );

  // R9
  reload_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !lk_ready_o);
  // R4
  page_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_valid_i && lk_ready_o && (lk_addr_i[31:12] >= 20'(MAX_ENTRIES)))
      |=> (rsp_valid_o && rsp_fault_o));
  // R7
  empty_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reload && n_used == '0) |=> (lk_ready_o && !mem_req_o));
endmodule

// File: tb/tb_dma_xlate_unit.sv
module tb_dma_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        snp_valid = 1'b0;
  logic [31:0] snp_addr = '0, snp_data = '0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = '0;
  logic        lk_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr;

  always #5 clk = ~clk;

  dma_xlate_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .snp_valid_i(snp_valid), .snp_addr_i(snp_addr), .snp_data_i(snp_data),
    .lk_valid_i(lk_valid), .lk_addr_i(lk_addr), .lk_ready_o(lk_ready),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [31:0] exp_base = '0, exp_limit = '0, exp_bm = '0;
  int exp_n = 0;
  logic [31:0] ovr [logic [31:0]];

  // memory model: default frames derived from the address, overrides from snoops
  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (ovr.exists(a)) return ovr[a];
    if ((a[14:3] % 5) == 3) return 32'h0;
    return {6'h01, a[21:20], a[14:3], 12'h321};
  endfunction

  logic        p1_v = 0, p2_v = 0;
  logic [31:0] p1_a = 0, p2_a = 0, first_addr = 0;
  int          fetch_cnt = 0;
  bit          first_seen = 0;
  always @(negedge clk) begin
    mem_rvalid = p2_v;
    mem_rdata  = p2_v ? mem_word(p2_a) : 32'h0;
    p2_v = p1_v; p2_a = p1_a;
    p1_v = mem_req; p1_a = mem_addr;
    if (mem_req) begin
      fetch_cnt++;
      if (!first_seen) begin first_addr = mem_addr; first_seen = 1; end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [31:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    if (sel) exp_limit = d; else exp_base = d;
    exp_bm = exp_base & 32'h7FFF_FFFF;
    exp_n  = ((exp_limit >> 3) >= 512) ? 512 : int'(exp_limit >> 3);
    @(negedge clk);
    reg_we = 0; reg_sel = 0;
    fetch_cnt = 0; first_seen = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !lk_ready; i++) @(negedge clk);
  endtask

  task automatic snoop(input logic [31:0] a, input logic [31:0] d);
    snp_valid = 1; snp_addr = a; snp_data = d; ovr[a] = d;
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic lookup(input logic [31:0] la, input string rq);
    logic [31:0] w, ep;
    bit ef, stray;
    int pg;
    pg = int'(la >> 12);
    w  = mem_word(exp_bm + 32'(pg) * 8);
    ef = (pg >= exp_n) || (pg >= 512) || (w == 0);
    ep = ef ? 32'h0 : {w[31:12], la[11:0]};
    stray = 0;
    lk_valid = 1; lk_addr = la;
    while (!lk_ready) begin
      if (rsp_valid) stray = 1;
      @(negedge clk);
    end
    @(negedge clk);
    lk_valid = 0;
    chk(!stray, "R9 response while stalled", 32'(stray), 0);
    chk(rsp_valid === 1'b1, {rq, " rsp_valid"}, 32'(rsp_valid), 1);
    chk(rsp_fault === ef, {rq, " fault"}, 32'(rsp_fault), 32'(ef));
    chk(rsp_paddr === ep, {rq, " paddr"}, rsp_paddr, ep);
  endtask

  task automatic t_reset();
    reg_sel = 0; #1;
    chk(reg_rdata === 0, "R1 base after reset", reg_rdata, 0);
    reg_sel = 1; #1;
    chk(reg_rdata === 0, "R1 limit after reset", reg_rdata, 0);
    reg_sel = 0;
    chk(lk_ready === 1, "R1 ready after reset", 32'(lk_ready), 1);
    lookup(32'h0000_1234, "R1 page1 unmapped");
    lookup(32'h0000_0000, "R1 page0 unmapped");
  endtask

  task automatic t_basic();
    reg_wr(0, 32'h8010_0000);
    chk(lk_ready === 0, "R9 stall after base write", 32'(lk_ready), 0);
    wait_ready();
    reg_wr(1, 32'h0000_0100);
    chk(lk_ready === 0, "R9 stall after limit write", 32'(lk_ready), 0);
    lookup(32'h0000_1abc, "R9 held lookup R2");
    chk(fetch_cnt == 32, "R10 fetch count 32", 32'(fetch_cnt), 32);
    chk(first_addr === 32'h0010_0000, "R5 first fetch addr", first_addr, 32'h0010_0000);
    reg_sel = 0; #1;
    chk(reg_rdata === 32'h8010_0000, "R11 R5 base readback", reg_rdata, 32'h8010_0000);
    reg_sel = 1; #1;
    chk(reg_rdata === 32'h0000_0100, "R11 limit readback", reg_rdata, 32'h100);
    reg_sel = 0;
    lookup(32'h0000_0000, "R2 page0");
    lookup(32'h0000_4fff, "R2 page4");
    lookup(32'h0000_3010, "R3 zero frame page3");
    lookup(32'h0000_8000, "R3 zero frame page8");
    lookup(32'h0001_f7e5, "R4 last usable page31");
    lookup(32'h0002_0000, "R4 page32 beyond limit");
    lookup(32'h0060_0000, "R4 page above 512");
  endtask

  task automatic t_snoop();
    snoop(32'h0010_0018, 32'h0077_7abc);
    lookup(32'h0000_3fff, "R8 snooped frame page3");
    snoop(32'h0010_000c, 32'hdead_0000);
    lookup(32'h0000_1004, "R8 owner write ignored");
    snoop(32'h0010_0140, 32'h0055_5000);
    lookup(32'h0002_8000, "R8 outside region");
    snoop(32'h0010_0010, 32'h0000_0000);
    lookup(32'h0000_2000, "R8 R3 snooped zero");
  endtask

  task automatic t_clamp();
    reg_wr(1, 32'h2000_0000);
    wait_ready();
    chk(fetch_cnt == 512, "R10 R4 clamp fetch count", 32'(fetch_cnt), 512);
    lookup(32'h001f_f123, "R4 page511");
    lookup(32'h0020_0123, "R4 page512");
    lookup(32'h0000_3456, "R6 reload sees memory");
  endtask

  task automatic t_reload();
    reg_wr(1, 32'h0000_0100);
    wait_ready();
    reg_wr(0, 32'h0020_0000);
    wait_ready();
    lookup(32'h0000_1222, "R6 new base page1");
    reg_wr(0, 32'h0030_0000);
    @(negedge clk);
    @(negedge clk);
    reg_wr(1, 32'h0000_0080);
    wait_ready();
    chk(fetch_cnt == 16, "R6 R10 restart count", 32'(fetch_cnt), 16);
    chk(first_addr === 32'h0030_0000, "R6 restart first addr", first_addr, 32'h0030_0000);
    lookup(32'h0000_0abc, "R6 restart page0");
    lookup(32'h0000_1abc, "R6 restart page1");
    lookup(32'h0000_f000, "R6 page15");
    lookup(32'h0001_0000, "R4 R6 page16");
  endtask

  task automatic t_zero();
    reg_wr(1, 32'h0);
    chk(lk_ready === 0, "R9 stall on zero limit", 32'(lk_ready), 0);
    wait_ready();
    chk(fetch_cnt == 0, "R7 no fetch", 32'(fetch_cnt), 0);
    lookup(32'h0000_0000, "R7 page0");
    lookup(32'h0000_1000, "R7 page1");
    reg_sel = 1; #1;
    chk(reg_rdata === 0, "R11 limit zero", reg_rdata, 0);
    reg_sel = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_snoop();
    t_clamp();
    t_reload();
    t_zero();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule